// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a test access port for a device with a configurable number of bidirectional pins. A serial test clock steps the sixteen-state controller using the mode-select input. The data input feeds either a 3-bit instruction path or one of two data paths: a one-bit pass-through register, or a chain of three cells per pin. The three cells of a pin observe and override its input, output and output-enable signals. The block sits between the core's functional pin signals and the pad buffers.

In normal operation the core owns the pads. A test host loads an opcode and then shifts data. Depending on the opcode, the pads are then driven from latched scan data, held at latched values while the chain is bypassed, or forced to high impedance. The serial output changes on the falling test-clock edge and is enabled only while a shift state is active.

Top module: `jtag_bscan_tap`

## Requirements
- R1: While `trst_n` is low the controller is held in Test-Logic-Reset and the active opcode is BYPASS. `tdo_oe` is 0, `pad_out` equals `core_out` and `pad_oe` equals `core_oe`.
- R2: Five consecutive `tck` rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. On the following falling edge the active opcode becomes BYPASS, so the pads return to core control.
- R3: In Capture-IR the instruction shift stage loads 3'b001. In Shift-IR it shifts toward bit 0, which is presented on `tdo`, while `tdi` enters bit 2. The shifted opcode becomes active only on the falling `tck` edge in Update-IR.
- R4: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is 1 exactly when the controller is in Shift-DR or Shift-IR.
- R5: The opcodes are 000 external test, 001 sample/preload, 101 high-impedance, 110 clamp and 111 bypass. The codes 010, 011 and 100 act as bypass.
- R6: Under bypass, clamp, high-impedance and the unassigned codes, the data path is the one-bit register. Capture-DR loads 0 into it, so a scan returns 0 followed by the input bits delayed by one shift.
- R7: The boundary chain has 3*NUM_IO cells. For pin i, bit 3i is the input cell, bit 3i+1 the output cell and bit 3i+2 the enable cell. Bit 0 is presented on `tdo`, and `tdi` enters bit 3*NUM_IO-1.
- R8: Under external test or sample/preload, Capture-DR loads `pad_in`, `pad_out` and `pad_oe` into the input, output and enable cells.
- R9: Under sample/preload and the bypass-type opcodes other than clamp and high-impedance, the pads follow the core. `core_in` always equals `pad_in`.
- R10: Under external test and clamp, `pad_out[i]` and `pad_oe[i]` come from the latched output and enable cells of pin i.
- R11: Under high-impedance every bit of `pad_oe` is 0.
- R12: The latched boundary contents change only on the falling edge in Update-DR, and only while external test or sample/preload is active. The pads stay stable throughout shifting, and data preloaded under sample/preload is what external test drives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Enable for `tdo`, high only in shift states |
| core_out | input | NUM_IO | Functional output values from the core |
| core_oe | input | NUM_IO | Functional output enables from the core |
| core_in | output | NUM_IO | Pad input values returned to the core |
| pad_out | output | NUM_IO | Output value to the pad buffers |
| pad_oe | output | NUM_IO | Output enable to the pad buffers |
| pad_in | input | NUM_IO | Input value from the pad buffers |

## Verification
The bench builds the block with NUM_IO = 4, which gives a 12-cell chain. At that size a full capture of every pin's three cells can be checked bit by bit in a single scan. Distinct patterns of core outputs, enables and pad inputs are walked through sample/preload. The last preload then feeds external test, and the bench confirms that clamp and high-impedance leave the latched cells untouched. The small width keeps each scan short, so every opcode, including the three unassigned codes, is exercised along with a TMS-driven reset taken from Pause-DR.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET    = 4'h0,
        ST_IDLE     = 4'h1,
        ST_DR_SEL   = 4'h2,
        ST_DR_CAP   = 4'h3,
        ST_DR_SHIFT = 4'h4,
        ST_DR_EXIT1 = 4'h5,
        ST_DR_PAUSE = 4'h6,
        ST_DR_EXIT2 = 4'h7,
        ST_DR_UPD   = 4'h8,
        ST_IR_SEL   = 4'h9,
        ST_IR_CAP   = 4'hA,
        ST_IR_SHIFT = 4'hB,
        ST_IR_EXIT1 = 4'hC,
        ST_IR_PAUSE = 4'hD,
        ST_IR_EXIT2 = 4'hE,
        ST_IR_UPD   = 4'hF
    } tap_state_e;

    typedef enum logic [2:0] {
        MODE_EXTEST,
        MODE_SAMPLE,
        MODE_HIGHZ,
        MODE_CLAMP,
        MODE_BYPASS
    } tap_mode_e;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] OP_EXTEST   = 3'b000;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b001;
    localparam logic [IR_W-1:0] OP_HIGHZ    = 3'b101;
    localparam logic [IR_W-1:0] OP_CLAMP    = 3'b110;
    localparam logic [IR_W-1:0] OP_BYPASS   = 3'b111;
    localparam logic [IR_W-1:0] IR_CAP_PAT  = 3'b001;

    localparam int CELLS_PER_IO = 3;
    localparam int CELL_IN  = 0;
    localparam int CELL_OUT = 1;
    localparam int CELL_OE  = 2;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e st;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_RESET:    r_d.st = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     r_d.st = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   r_d.st = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   r_d.st = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_SHIFT: r_d.st = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
            ST_DR_EXIT1: r_d.st = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: r_d.st = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
            ST_DR_EXIT2: r_d.st = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   r_d.st = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   r_d.st = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   r_d.st = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_SHIFT: r_d.st = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
            ST_IR_EXIT1: r_d.st = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: r_d.st = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
            ST_IR_EXIT2: r_d.st = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   r_d.st = tms ? ST_DR_SEL   : ST_IDLE;
            default:     r_d.st = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) r_q.st <= ST_RESET;
        else         r_q    <= r_d;
    end

    assign state = r_q.st;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_lsb,
    output tap_mode_e  mode
);

    logic [IR_W-1:0] sr_d, sr_q;
    logic [IR_W-1:0] op_d, op_q;

    // shift stage, rising edge
    always_comb begin
        sr_d = sr_q;
        if (state == ST_IR_CAP)        sr_d = IR_CAP_PAT;
        else if (state == ST_IR_SHIFT) sr_d = {tdi, sr_q[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) sr_q <= IR_CAP_PAT;
        else         sr_q <= sr_d;
    end

    // active opcode, falling edge
    always_comb begin
        op_d = op_q;
        if (state == ST_RESET)       op_d = OP_BYPASS;
        else if (state == ST_IR_UPD) op_d = sr_q;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) op_q <= OP_BYPASS;
        else         op_q <= op_d;
    end

    always_comb begin
        case (op_q)
            OP_EXTEST: mode = MODE_EXTEST;
            OP_SAMPLE: mode = MODE_SAMPLE;
            OP_HIGHZ:  mode = MODE_HIGHZ;
            OP_CLAMP:  mode = MODE_CLAMP;
            default:   mode = MODE_BYPASS;
        endcase
    end

    assign ir_lsb = sr_q[0];

endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
    import tap_pkg::*;
#(
    parameter int NUM_IO = 4
) (
    input  logic                tck,
    input  logic                trst_n,
    input  tap_state_e          state,
    input  tap_mode_e           mode,
    input  logic                tdi,
    input  logic [NUM_IO-1:0]   core_out,
    input  logic [NUM_IO-1:0]   core_oe,
    input  logic [NUM_IO-1:0]   pad_in,
    output logic [NUM_IO-1:0]   pad_out,
    output logic [NUM_IO-1:0]   pad_oe,
    output logic                bsr_lsb,
    output logic [CELLS_PER_IO*NUM_IO-1:0] upd
);

    localparam int BSR_LEN = CELLS_PER_IO * NUM_IO;

    logic [BSR_LEN-1:0] sr_d, sr_q;
    logic [BSR_LEN-1:0] upd_d, upd_q;
    logic [BSR_LEN-1:0] cap_vec;
    logic               sel_chain;
    logic               drive_cells;
    logic               force_off;

    assign sel_chain   = (mode == MODE_EXTEST) || (mode == MODE_SAMPLE);
    assign drive_cells = (mode == MODE_EXTEST) || (mode == MODE_CLAMP);
    assign force_off   = (mode == MODE_HIGHZ);

    for (genvar i = 0; i < NUM_IO; i++) begin : g_pin
        localparam int B = CELLS_PER_IO * i;
        assign cap_vec[B+CELL_IN]  = pad_in[i];
        assign cap_vec[B+CELL_OUT] = pad_out[i];
        assign cap_vec[B+CELL_OE]  = pad_oe[i];
        assign pad_out[i] = drive_cells ? upd_q[B+CELL_OUT] : core_out[i];
        assign pad_oe[i]  = force_off   ? 1'b0 :
                            drive_cells ? upd_q[B+CELL_OE]  : core_oe[i];
    end

    always_comb begin
        sr_d = sr_q;
        if (sel_chain) begin
            if (state == ST_DR_CAP)        sr_d = cap_vec;
            else if (state == ST_DR_SHIFT) sr_d = {tdi, sr_q[BSR_LEN-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) sr_q <= '0;
        else         sr_q <= sr_d;
    end

    always_comb begin
        upd_d = upd_q;
        if (sel_chain && state == ST_DR_UPD) upd_d = sr_q;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) upd_q <= '0;
        else         upd_q <= upd_d;
    end

    assign bsr_lsb = sr_q[0];
    assign upd     = upd_q;

endmodule

// File: rtl/jtag_bscan_tap.sv
module jtag_bscan_tap
    import tap_pkg::*;
#(
    parameter int NUM_IO = 4
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    input  logic [NUM_IO-1:0] core_out,
    input  logic [NUM_IO-1:0] core_oe,
    output logic [NUM_IO-1:0] core_in,
    output logic [NUM_IO-1:0] pad_out,
    output logic [NUM_IO-1:0] pad_oe,
    input  logic [NUM_IO-1:0] pad_in
);

    localparam int BSR_LEN = CELLS_PER_IO * NUM_IO;

    typedef struct packed {
        logic byp;
    } rise_regs_t;

    typedef struct packed {
        logic dout;
        logic oe;
    } fall_regs_t;

    tap_state_e         state;
    tap_mode_e          mode;
    logic               ir_lsb;
    logic               bsr_lsb;
    logic [BSR_LEN-1:0] bsr_upd;
    logic               sel_chain;
    rise_regs_t         rr_d, rr_q;
    fall_regs_t         fr_d, fr_q;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .ir_lsb (ir_lsb),
        .mode   (mode)
    );

    tap_bsr #(.NUM_IO(NUM_IO)) u_bsr (
        .tck      (tck),
        .trst_n   (trst_n),
        .state    (state),
        .mode     (mode),
        .tdi      (tdi),
        .core_out (core_out),
        .core_oe  (core_oe),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .bsr_lsb  (bsr_lsb),
        .upd      (bsr_upd)
    );

    assign sel_chain = (mode == MODE_EXTEST) || (mode == MODE_SAMPLE);

    // one-bit pass-through register
    always_comb begin
        rr_d = rr_q;
        if (state == ST_DR_CAP)        rr_d.byp = 1'b0;
        else if (state == ST_DR_SHIFT) rr_d.byp = tdi;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) rr_q <= '0;
        else         rr_q <= rr_d;
    end

    // serial output, falling edge
    always_comb begin
        fr_d    = fr_q;
        fr_d.oe = 1'b0;
        if (state == ST_IR_SHIFT) begin
            fr_d.oe   = 1'b1;
            fr_d.dout = ir_lsb;
        end else if (state == ST_DR_SHIFT) begin
            fr_d.oe   = 1'b1;
            fr_d.dout = sel_chain ? bsr_lsb : rr_q.byp;
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) fr_q <= '0;
        else         fr_q <= fr_d;
    end

    assign tdo     = fr_q.dout;
    assign tdo_oe  = fr_q.oe;
    assign core_in = pad_in;

endmodule

// File: rtl/tap_checker.sv
module tap_checker
    import tap_pkg::*;
#(
    parameter int NUM_IO = 4
) (
    input logic                          tck,
    input logic                          trst_n,
    input logic                          tms,
    input tap_state_e                    state,
    input tap_mode_e                     mode,
    input logic [CELLS_PER_IO*NUM_IO-1:0] bsr_upd,
    input logic [NUM_IO-1:0]             core_out,
    input logic [NUM_IO-1:0]             core_oe,
    input logic [NUM_IO-1:0]             pad_out,
    input logic [NUM_IO-1:0]             pad_oe,
    input logic                          tdo_oe
);

    logic [2:0]        tms_run;
    logic [NUM_IO-1:0] cell_out;
    logic [NUM_IO-1:0] cell_oe;

    for (genvar i = 0; i < NUM_IO; i++) begin : g_cell
        assign cell_out[i] = bsr_upd[CELLS_PER_IO*i+CELL_OUT];
        assign cell_oe[i]  = bsr_upd[CELLS_PER_IO*i+CELL_OE];
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)            tms_run <= '0;
        else if (!tms)          tms_run <= '0;
        else if (tms_run < 3'd5) tms_run <= tms_run + 3'd1;
    end

    p_tms_reset_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run == 3'd5) |-> (state == ST_RESET));

    p_tdo_oe_shift_r4: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe == ((state == ST_DR_SHIFT) || (state == ST_IR_SHIFT)));

    p_core_owns_r9: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == MODE_SAMPLE || mode == MODE_BYPASS) |->
        (pad_out == core_out && pad_oe == core_oe));

    p_cells_drive_r10: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == MODE_EXTEST || mode == MODE_CLAMP) |->
        (pad_out == cell_out && pad_oe == cell_oe));

    p_highz_off_r11: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == MODE_HIGHZ) |-> (pad_oe == '0));

    p_upd_hold_r12: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_DR_SHIFT) |=> $stable(bsr_upd));

endmodule

bind jtag_bscan_tap tap_checker #(.NUM_IO(NUM_IO)) u_tap_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .state    (state),
    .mode     (mode),
    .bsr_upd  (bsr_upd),
    .core_out (core_out),
    .core_oe  (core_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .tdo_oe   (tdo_oe)
);

// File: tb/tb_jtag_bscan_tap.sv
module tb_jtag_bscan_tap;

    localparam int TCK_PERIOD = 20;
    localparam int NUM_IO     = 4;
    localparam int BSR_LEN    = 3 * NUM_IO;
    localparam int WATCHDOG   = 20000;

    // row layout: [11:8] core_out, [7:4] core_oe, [3:0] pad_in
    localparam int N_ROWS = 6;
    localparam logic [11:0] ROWS [N_ROWS] = '{
        12'h0F0, 12'hF0F, 12'hA5C, 12'h5A3, 12'h369, 12'hC96
    };
    localparam logic [2:0] SPARE_OPS [3] = '{3'b010, 3'b011, 3'b100};

    logic              tck = 1'b0;
    logic              trst_n;
    logic              tms;
    logic              tdi;
    logic              tdo;
    logic              tdo_oe;
    logic [NUM_IO-1:0] core_out;
    logic [NUM_IO-1:0] core_oe;
    logic [NUM_IO-1:0] core_in;
    logic [NUM_IO-1:0] pad_out;
    logic [NUM_IO-1:0] pad_oe;
    logic [NUM_IO-1:0] pad_in;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    jtag_bscan_tap #(.NUM_IO(NUM_IO)) dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
    );

    initial forever #(TCK_PERIOD/2) tck = ~tck;

    always @(posedge tck) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog act=%0d exp<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] cap_exp(input logic [3:0] po, input logic [3:0] oe,
                                            input logic [3:0] pi);
        logic [11:0] r;
        for (int i = 0; i < NUM_IO; i++) begin
            r[3*i]   = pi[i];
            r[3*i+1] = po[i];
            r[3*i+2] = oe[i];
        end
        return r;
    endfunction

    function automatic logic [3:0] dec_out(input logic [11:0] v);
        logic [3:0] r;
        for (int i = 0; i < NUM_IO; i++) r[i] = v[3*i+1];
        return r;
    endfunction

    function automatic logic [3:0] dec_oe(input logic [11:0] v);
        logic [3:0] r;
        for (int i = 0; i < NUM_IO; i++) r[i] = v[3*i+2];
        return r;
    endfunction

    // drive while tck low, read the bit the next device would take, step one cycle
    task automatic tick(input logic m, input logic d, output logic o);
        tms = m;
        tdi = d;
        o   = tdo;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic load_ir(input logic [2:0] op, output logic [2:0] seen);
        logic o;
        tick(1'b1, 1'b0, o);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        for (int k = 0; k < 3; k++) begin
            tick(k == 2, op[k], o);
            seen[k] = o;
        end
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout,
                           output int moved, output int oe_off);
        logic o;
        logic [NUM_IO-1:0] po0, oe0;
        dout = '0;
        moved = 0;
        oe_off = 0;
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        po0 = pad_out;
        oe0 = pad_oe;
        for (int k = 0; k < n; k++) begin
            if (tdo_oe !== 1'b1) oe_off++;
            tick(k == n - 1, din[k], o);
            dout[k] = o;
            if (pad_out !== po0 || pad_oe !== oe0) moved++;
        end
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
    endtask

    logic [63:0] dout;
    logic [2:0]  seen;
    logic [11:0] pre;
    logic [11:0] q_scan;
    logic        o;
    int          moved;
    int          oe_off;

    initial begin
        trst_n   = 1'b0;
        tms      = 1'b1;
        tdi      = 1'b0;
        core_out = 4'h6;
        core_oe  = 4'hA;
        pad_in   = 4'h3;
        pre      = '0;
        repeat (3) @(negedge tck);
        #1;
        // R1: reset state
        check("R1 tdo_oe in reset", {31'b0, tdo_oe}, 32'd0);
        check("R1 pad_out follows core", {28'b0, pad_out}, {28'b0, core_out});
        check("R1 pad_oe follows core", {28'b0, pad_oe}, {28'b0, core_oe});
        trst_n = 1'b1;
        tick(1'b0, 1'b0, o);
        check("R4 tdo_oe idle", {31'b0, tdo_oe}, 32'd0);

        // R1/R6: after reset the active path is the one-bit register
        scan_dr(6, 64'h2D, dout, moved, oe_off);
        check("R6 bypass after reset", dout[31:0], 32'h1A);
        check("R4 tdo_oe during shift", oe_off, 0);

        // R3/R5: load sample/preload, see capture pattern
        load_ir(3'b001, seen);
        check("R3 ir capture pattern", {29'b0, seen}, 32'd1);

        // table walk under sample/preload: R7 R8 R9 R12
        for (int j = 0; j < N_ROWS; j++) begin
            core_out = ROWS[j][11:8];
            core_oe  = ROWS[j][7:4];
            pad_in   = ROWS[j][3:0];
            pre      = ROWS[j] ^ 12'hA5C;
            #1;
            check("R9 sample pads follow core", {24'b0, pad_out, pad_oe},
                  {24'b0, core_out, core_oe});
            check("R9 core_in is pad_in", {28'b0, core_in}, {28'b0, pad_in});
            scan_dr(BSR_LEN, {52'b0, pre}, dout, moved, oe_off);
            check("R8 R7 sample capture", dout[31:0],
                  {20'b0, cap_exp(ROWS[j][11:8], ROWS[j][7:4], ROWS[j][3:0])});
            check("R12 pads still during sample scan", moved, 0);
        end

        // R10/R12: external test drives the preloaded cells
        load_ir(3'b000, seen);
        check("R3 ir capture pattern again", {29'b0, seen}, 32'd1);
        check("R10 R12 extest preload out", {28'b0, pad_out}, {28'b0, dec_out(pre)});
        check("R10 R12 extest preload oe", {28'b0, pad_oe}, {28'b0, dec_oe(pre)});
        pad_in = 4'h9;
        q_scan = 12'h3C6;
        scan_dr(BSR_LEN, {52'b0, q_scan}, dout, moved, oe_off);
        check("R8 extest capture", dout[31:0],
              {20'b0, cap_exp(dec_out(pre), dec_oe(pre), 4'h9)});
        check("R12 pads stable during extest shift", moved, 0);
        check("R10 R12 extest after update", {24'b0, pad_out, pad_oe},
              {24'b0, dec_out(q_scan), dec_oe(q_scan)});

        // R11: high impedance, bypass path, cells untouched
        load_ir(3'b101, seen);
        check("R11 highz enables off", {28'b0, pad_oe}, 32'd0);
        scan_dr(8, 64'hB2, dout, moved, oe_off);
        check("R6 highz uses bypass", dout[31:0], 32'h64);

        // R10/R12: clamp shows cells unchanged by the highz scan
        load_ir(3'b110, seen);
        check("R10 clamp drives cells", {24'b0, pad_out, pad_oe},
              {24'b0, dec_out(q_scan), dec_oe(q_scan)});
        scan_dr(8, 64'h5B, dout, moved, oe_off);
        check("R6 clamp uses bypass", dout[31:0], 32'hB6);
        check("R12 clamp scan leaves cells", {24'b0, pad_out, pad_oe},
              {24'b0, dec_out(q_scan), dec_oe(q_scan)});

        // R5: bypass and unassigned codes
        load_ir(3'b111, seen);
        check("R9 bypass pads follow core", {24'b0, pad_out, pad_oe},
              {24'b0, core_out, core_oe});
        for (int u = 0; u < 3; u++) begin
            load_ir(3'b000, seen);
            load_ir(SPARE_OPS[u], seen);
            check("R5 spare code pads follow core", {24'b0, pad_out, pad_oe},
                  {24'b0, core_out, core_oe});
            scan_dr(5, 64'h13, dout, moved, oe_off);
            check("R5 spare code uses bypass", dout[31:0], 32'h06);
        end

        // R2: TMS reset from Pause-DR under external test
        load_ir(3'b000, seen);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b0, 1'b0, o);
        tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        check("R4 tdo_oe off in pause", {31'b0, tdo_oe}, 32'd0);
        for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, o);
        check("R2 tms reset returns pads to core", {24'b0, pad_out, pad_oe},
              {24'b0, core_out, core_oe});
        tick(1'b0, 1'b0, o);
        scan_dr(6, 64'h2D, dout, moved, oe_off);
        check("R2 bypass after tms reset", dout[31:0], 32'h1A);

        // R1: asynchronous reset while external test is active
        load_ir(3'b000, seen);
        core_out = 4'h5;
        core_oe  = 4'hC;
        trst_n   = 1'b0;
        #1;
        check("R1 async reset pads to core", {24'b0, pad_out, pad_oe}, {24'b0, 4'h5, 4'hC});
        check("R1 async reset tdo_oe", {31'b0, tdo_oe}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule